// File: doc/BRIEF.md
# Device Power-State Reset Sequencer

This block follows a peripheral's power-management state through a host-driven fundamental reset. An active-low reset input sends the device into the reset state at once, whatever its state was. When the reset is released, a single cycle counter starts. It only advances while the reference clock is reported as running. Each readiness signal is opened at its own threshold of that counter: internal clock valid, internal power-good, link training, acceptance of configuration accesses, and permission to send configuration responses.

When power-good first rises, the block asks for a reload of the configuration EEPROM and clears the wake-up enable. The wake-up enable is then taken from a bit that the reload returns. Once responses are allowed and the reload has finished, the device sits in an uninitialised D0. A configuration write that sets the memory-access-enable bit promotes it to active D0. After that move, device accesses are honoured only once a settle interval has passed. The nominal interval is 10 ms, scaled here to a cycle count. Clearing the bit demotes the device back to uninitialised D0.

Top module: `pwrseq_top`

## Requirements
- R1: While `prst_n` is low, `dev_state` reads 2'b10 (reset state) at once, without waiting for a clock edge. `clk_valid`, `pwr_good`, `link_train`, `cfg_resp_ok`, `mem_ok`, `wake_en`, `cfg_ack` and `cfg_retry` are low and `link_idle` is high. A new assertion in the middle of a sequence restarts the sequence from the beginning.
- R2: The release of `prst_n` takes effect after SYNC_STAGES clock edges. From then on, the elapsed count N rises by one on each edge where `refclk_ok` is high, saturating at T_RES. N does not change while `refclk_ok` is low.
- R3: `clk_valid` is high exactly when N >= T_CLK.
- R4: `pwr_good` is high exactly when N >= T_PG. `pg_pulse` is high for the single cycle in which N first reaches T_PG.
- R5: At the edge that samples `pg_pulse`, `ee_reload_req` rises and `wake_en` clears. At the first edge after that which samples `ee_done` high, `ee_reload_req` falls and `wake_en` takes the value of `ee_wake_bit`. `ee_done` has no effect while no request is pending.
- R6: `link_train` is high exactly when N >= T_TRN. `link_idle` is its complement, so the link stays in electrical idle throughout the reset state until training starts.
- R7: A `cfg_req` sampled at an edge gets a one-cycle answer after that edge. The answer is `cfg_ack` if N was >= T_CFG at that edge and `cfg_retry` otherwise. The two are never high together.
- R8: `cfg_resp_ok` is high exactly when N >= T_RES.
- R9: The state moves from 2'b10 to 2'b01 (uninitialised D0) at the first edge where N >= T_RES and the EEPROM reload has completed.
- R10: A `cmd_wr` with `cmd_mae`=1 moves 2'b01 to 2'b00 (active D0). A `cmd_wr` with `cmd_mae`=0 moves 2'b00 to 2'b01. `cmd_wr` is ignored in the reset state.
- R11: `mem_ok` is high only in 2'b00, and only once T_D0MEM edges have passed since the edge that entered 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| prst_n | input | 1 | Fundamental reset, active low, asynchronous assert |
| refclk_ok | input | 1 | Reference clock running |
| cfg_req | input | 1 | Configuration access arrives |
| cmd_wr | input | 1 | Write strobe to the command register |
| cmd_mae | input | 1 | Memory-access-enable bit of that write |
| ee_done | input | 1 | EEPROM reload finished |
| ee_wake_bit | input | 1 | Wake-enable bit returned by the reload |
| clk_valid | output | 1 | Internal clock settled |
| pwr_good | output | 1 | Internal power-good level |
| pg_pulse | output | 1 | One-cycle pulse when power-good rises |
| ee_reload_req | output | 1 | EEPROM reload request |
| wake_en | output | 1 | Wake-up enable |
| link_train | output | 1 | Link training enabled |
| link_idle | output | 1 | Link held in electrical idle |
| cfg_ack | output | 1 | Configuration access accepted |
| cfg_retry | output | 1 | Configuration access must be retried |
| cfg_resp_ok | output | 1 | Configuration responses allowed |
| mem_ok | output | 1 | Device accesses honoured |
| dev_state | output | 2 | 2'b00 active D0, 2'b01 uninitialised D0, 2'b10 reset state |

## Verification
The embedded properties check several rules on every cycle:
- the elapsed count never decreases within a sequence;
- the power-good pulse lasts a single cycle;
- a reload request rises only after that pulse;
- accept and retry never coincide, and an accept only follows a request inside the open window;
- active D0 is reached only from uninitialised D0, and device accesses are honoured only there.

The exact cycle at which each threshold opens can only be shown by the bench's cycle-by-cycle sweeps after reset release. The same holds for the way a mid-sequence reset restarts every stage, for the counter freezing while the reference clock is absent, and for the length of the settle window.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
   typedef enum logic [1:0] {
      PS_D0A = 2'b00,
      PS_D0U = 2'b01,
      PS_DR  = 2'b10
   } pstate_e;

   localparam int NUM_MS = 5;
endpackage

// File: rtl/pwrseq_rst_sync.sv
module pwrseq_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("pwrseq_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
   parameter int MAXV = 12,
   localparam int CW = $clog2(MAXV + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   output logic [CW-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (en && (cnt < CW'(MAXV)))   cnt <= cnt + CW'(1);
   end

   AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt >= $past(cnt)));                                   // R2
endmodule

// File: rtl/pwrseq_settle.sv
module pwrseq_settle #(
   parameter int T_SETTLE = 5,
   localparam int SW = $clog2(T_SETTLE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic active,
   output logic done
);
   logic [SW-1:0] scnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     scnt <= '0;
      else if (start)                                 scnt <= '0;
      else if (active && (scnt < SW'(T_SETTLE)))      scnt <= scnt + SW'(1);
   end

   assign done = active && (scnt == SW'(T_SETTLE));
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
   import pwrseq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int T_CLK       = 4,
   parameter int T_PG        = 6,
   parameter int T_TRN       = 8,
   parameter int T_CFG       = 10,
   parameter int T_RES       = 12,
   parameter int T_D0MEM     = 5
) (
   input  logic       clk,
   input  logic       prst_n,
   input  logic       refclk_ok,
   input  logic       cfg_req,
   input  logic       cmd_wr,
   input  logic       cmd_mae,
   input  logic       ee_done,
   input  logic       ee_wake_bit,
   output logic       clk_valid,
   output logic       pwr_good,
   output logic       pg_pulse,
   output logic       ee_reload_req,
   output logic       wake_en,
   output logic       link_train,
   output logic       link_idle,
   output logic       cfg_ack,
   output logic       cfg_retry,
   output logic       cfg_resp_ok,
   output logic       mem_ok,
   output logic [1:0] dev_state
);
   localparam int CW = $clog2(T_RES + 1);
   localparam int THR [NUM_MS] = '{T_CLK, T_PG, T_TRN, T_CFG, T_RES};

   generate
      if (T_CLK < 1 || T_CLK > T_PG || T_PG > T_TRN || T_TRN > T_CFG || T_CFG > T_RES)
      begin : g_bad_order
         $error("pwrseq_top: thresholds must satisfy 1 <= T_CLK <= T_PG <= T_TRN <= T_CFG <= T_RES");
      end
      if (T_D0MEM < 1) begin : g_bad_settle
         $error("pwrseq_top: T_D0MEM must be at least 1");
      end
   endgenerate

   logic              srst_n;
   logic [CW-1:0]     cnt;
   logic [NUM_MS-1:0] ms;
   logic              pg_q, ee_loaded, promote;
   pstate_e           state;

   pwrseq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .arst_n(prst_n), .srst_n(srst_n));

   pwrseq_timer #(.MAXV(T_RES)) u_timer (
      .clk(clk), .rst_n(srst_n), .en(refclk_ok), .cnt(cnt));

   // one comparator per readiness stage, all against the shared count
   generate
      for (genvar gi = 0; gi < NUM_MS; gi++) begin : g_ms
         assign ms[gi] = (cnt >= CW'(THR[gi]));
      end
   endgenerate

   assign clk_valid   = ms[0];
   assign pwr_good    = ms[1];
   assign link_train  = ms[2];
   assign link_idle   = ~ms[2];
   assign cfg_resp_ok = ms[4];
   assign pg_pulse    = ms[1] & ~pg_q;
   assign dev_state   = state;
   assign promote     = (state == PS_D0U) && cmd_wr && cmd_mae;

   always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
         pg_q          <= 1'b0;
         ee_reload_req <= 1'b0;
         ee_loaded     <= 1'b0;
         wake_en       <= 1'b0;
      end else begin
         pg_q <= ms[1];
         if (pg_pulse) begin
            ee_reload_req <= 1'b1;
            wake_en       <= 1'b0;
         end else if (ee_reload_req && ee_done) begin
            ee_reload_req <= 1'b0;
            ee_loaded     <= 1'b1;
            wake_en       <= ee_wake_bit;
         end
      end
   end

   always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
         cfg_ack   <= 1'b0;
         cfg_retry <= 1'b0;
      end else begin
         cfg_ack   <= cfg_req &  ms[3];
         cfg_retry <= cfg_req & ~ms[3];
      end
   end

   always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) state <= PS_DR;
      else begin
         unique case (state)
            PS_DR:   if (ms[4] && ee_loaded)     state <= PS_D0U;
            PS_D0U:  if (cmd_wr && cmd_mae)      state <= PS_D0A;
            PS_D0A:  if (cmd_wr && !cmd_mae)     state <= PS_D0U;
            default:                             state <= PS_DR;
         endcase
      end
   end

   pwrseq_settle #(.T_SETTLE(T_D0MEM)) u_settle (
      .clk(clk), .rst_n(srst_n), .start(promote),
      .active(state == PS_D0A), .done(mem_ok));

   AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!srst_n)
      !(cfg_ack && cfg_retry));                                        // R7
   AST_ACK_IN_WINDOW: assert property (@(posedge clk) disable iff (!srst_n)
      cfg_ack |-> ($past(cfg_req) && $past(ms[3])));                   // R7
   AST_PG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!srst_n)
      pg_pulse |=> !pg_pulse);                                         // R4
   AST_REQ_AFTER_PG: assert property (@(posedge clk) disable iff (!srst_n)
      $rose(ee_reload_req) |-> $past(pg_pulse));                       // R5
   AST_D0A_ENTRY: assert property (@(posedge clk) disable iff (!srst_n)
      (state == PS_D0A && $past(state) != PS_D0A) |-> ($past(state) == PS_D0U)); // R10
   AST_MEM_IN_D0A: assert property (@(posedge clk) disable iff (!srst_n)
      mem_ok |-> (state == PS_D0A));                                   // R11
   AST_TRAIN_AFTER_PG: assert property (@(posedge clk) disable iff (!srst_n)
      link_train |-> pwr_good);                                        // R6
endmodule

// File: tb/pwrseq_top_tb_top.sv
module pwrseq_top_tb_top;
   localparam int CLK_P   = 10;
   localparam int SYNC    = 2;
   localparam int T_CLK   = 4;
   localparam int T_PG    = 6;
   localparam int T_TRN   = 8;
   localparam int T_CFG   = 10;
   localparam int T_RES   = 12;
   localparam int T_D0MEM = 5;

   logic clk = 1'b0;
   logic prst_n, refclk_ok, cfg_req, cmd_wr, cmd_mae, ee_done, ee_wake_bit;
   logic clk_valid, pwr_good, pg_pulse, ee_reload_req, wake_en, link_train, link_idle;
   logic cfg_ack, cfg_retry, cfg_resp_ok, mem_ok;
   logic [1:0] dev_state;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pwrseq_top #(.SYNC_STAGES(SYNC), .T_CLK(T_CLK), .T_PG(T_PG), .T_TRN(T_TRN),
                .T_CFG(T_CFG), .T_RES(T_RES), .T_D0MEM(T_D0MEM)) dut_i (
      .clk(clk), .prst_n(prst_n), .refclk_ok(refclk_ok), .cfg_req(cfg_req),
      .cmd_wr(cmd_wr), .cmd_mae(cmd_mae), .ee_done(ee_done), .ee_wake_bit(ee_wake_bit),
      .clk_valid(clk_valid), .pwr_good(pwr_good), .pg_pulse(pg_pulse),
      .ee_reload_req(ee_reload_req), .wake_en(wake_en), .link_train(link_train),
      .link_idle(link_idle), .cfg_ack(cfg_ack), .cfg_retry(cfg_retry),
      .cfg_resp_ok(cfg_resp_ok), .mem_ok(mem_ok), .dev_state(dev_state));

   task automatic chk(input logic got, input logic exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic chk_st(input logic [1:0] exp, input string tag);
      checks++;
      if (dev_state !== exp) begin
         errors++;
         $display("FAIL %s: state got %b expected %b at %0t", tag, dev_state, exp, $time);
      end
   endtask

   task automatic reset_outputs(input string tag);
      chk_st(2'b10, tag);
      chk(clk_valid, 1'b0, tag);
      chk(pwr_good, 1'b0, tag);
      chk(link_train, 1'b0, tag);
      chk(link_idle, 1'b1, tag);
      chk(cfg_resp_ok, 1'b0, tag);
      chk(mem_ok, 1'b0, tag);
      chk(wake_en, 1'b0, tag);
      chk(cfg_ack, 1'b0, tag);
      chk(cfg_retry, 1'b0, tag);
   endtask

   // full sweep from reset release; e counts edges after release
   task automatic run_seq(input logic wb);
      @(negedge clk);
      prst_n = 1'b0; ee_done = 1'b0; cfg_req = 1'b0; cmd_wr = 1'b0;
      repeat (3) @(negedge clk);
      ee_wake_bit = wb;
      cfg_req = 1'b1; cmd_wr = 1'b1; cmd_mae = 1'b1;
      prst_n = 1'b1;
      for (int e = 1; e <= T_RES + 6; e++) begin
         int ce;
         @(posedge clk);
         @(negedge clk);
         ce = e - SYNC;
         chk(clk_valid,     ce >= T_CLK,  "R3 clk_valid");
         chk(pwr_good,      ce >= T_PG,   "R4 pwr_good");
         chk(pg_pulse,      ce == T_PG,   "R4 pg_pulse");
         chk(ee_reload_req, e == SYNC + T_PG + 1, "R5 reload_req");
         chk(wake_en,       (e >= SYNC + T_PG + 2) ? wb : 1'b0, "R5 wake_en");
         chk(link_train,    ce >= T_TRN,  "R6 link_train");
         chk(link_idle,     ce <  T_TRN,  "R6 link_idle");
         chk(cfg_ack,       (e > SYNC) && (ce - 1 >= T_CFG), "R7 cfg_ack");
         chk(cfg_retry,     (e > SYNC) && (ce - 1 <  T_CFG), "R7 cfg_retry");
         chk(cfg_resp_ok,   ce >= T_RES,  "R8 cfg_resp_ok");
         chk_st((e >= SYNC + T_RES + 1) ? 2'b01 : 2'b10, "R9/R10 state");
         ee_done = ee_reload_req;
         cmd_wr  = (e + 1 <= SYNC + T_RES);
      end
      cfg_req = 1'b0; cmd_wr = 1'b0; ee_done = 1'b0;
   endtask

   initial begin
      prst_n = 1'b0; refclk_ok = 1'b1; cfg_req = 1'b0; cmd_wr = 1'b0;
      cmd_mae = 1'b0; ee_done = 1'b0; ee_wake_bit = 1'b0;
      repeat (4) @(negedge clk);
      reset_outputs("R1 reset state");

      run_seq(1'b0);

      // promotion and settle window
      @(negedge clk); cmd_wr = 1'b1; cmd_mae = 1'b1;
      @(negedge clk); cmd_wr = 1'b0;
      chk_st(2'b00, "R10 promote");
      chk(mem_ok, 1'b0, "R11 settle start");
      for (int n = 1; n <= T_D0MEM + 2; n++) begin
         @(negedge clk);
         chk(mem_ok, n >= T_D0MEM, "R11 settle window");
      end
      @(negedge clk); cmd_wr = 1'b1; cmd_mae = 1'b0;
      @(negedge clk); cmd_wr = 1'b0;
      chk_st(2'b01, "R10 demote");
      chk(mem_ok, 1'b0, "R11 demoted");
      // re-promote: window restarts
      @(negedge clk); cmd_wr = 1'b1; cmd_mae = 1'b1;
      @(negedge clk); cmd_wr = 1'b0;
      chk(mem_ok, 1'b0, "R11 window restarts");

      // reset mid-sequence, asynchronous effect
      run_seq(1'b1);
      @(negedge clk); prst_n = 1'b0;
      #1;
      reset_outputs("R1 async reset");
      @(negedge clk); prst_n = 1'b1;
      repeat (SYNC + T_CLK + 1) @(negedge clk);
      prst_n = 1'b0;
      #1;
      reset_outputs("R1 mid-sequence reset");
      run_seq(1'b1);

      // counter frozen while reference clock absent
      @(negedge clk); prst_n = 1'b0; refclk_ok = 1'b0;
      repeat (2) @(negedge clk);
      prst_n = 1'b1;
      repeat (SYNC + T_RES + 8) @(negedge clk);
      chk(clk_valid, 1'b0, "R2 frozen clk_valid");
      chk_st(2'b10, "R2 frozen state");
      refclk_ok = 1'b1;
      repeat (T_CLK - 1) @(negedge clk);
      chk(clk_valid, 1'b0, "R2 resume before threshold");
      @(negedge clk);
      chk(clk_valid, 1'b1, "R2 resume at threshold");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule